// File: doc/BRIEF.md
# Sleep Mode and Clock-Gating Controller

This block decides when a small processor core goes to sleep, which clock domains are switched off while it sleeps, and how it comes back. Software writes a sleep-enable bit and a 3-bit mode code into a control register. The block enters sleep only when the CPU also pulses a one-cycle sleep-instruction strobe while the enable bit is set. The mode code is captured when sleep is entered. It selects one of five sleep modes, and each mode has its own set of gated clock domains and its own set of permitted wake sources.

A permitted wake source moves the block into an oscillator start-up wait. The wait is long in the two deepest oscillator-off modes and zero in the others. A fixed halt of four cycles follows the wait. After the halt, a one-cycle pulse releases the pending interrupt to the CPU. A reset request that arrives during sleep ends the sequence at once and pulses a restart output instead, which sends the CPU to its reset vector. The clock-gating cells, the oscillators and the CPU are outside this block; they see only the enable vector and the pulses.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After `rst_n` is released, `clk_en` is all ones, `sleeping`, `irq_release` and `restart` are 0, and the control register holds enable 0 and mode 000.
- R2: A write (`cfg_we`) stores `cfg_wdata[0]` as sleep-enable and `cfg_wdata[3:1]` as the mode code. A `sleep_stb` pulse enters sleep only if the stored enable bit is already 1. A write in the same cycle as the strobe does not count for that strobe, and a strobe with the enable bit at 0 has no effect.
- R3: `clk_en` bit order is 0 CPU, 1 flash, 2 I/O, 3 ADC, 4 asynchronous timer. In Idle (code 000, and the unused codes 100, 101 and 111) only CPU and flash are gated.
- R4: In ADC noise reduction (code 001), CPU, flash and I/O are gated, ADC stays on, and the asynchronous timer domain stays on only when `asy_run` is 1.
- R5: Power-down (010) and standby (110) gate every domain. Power-save (011) gates every domain except the asynchronous timer domain, which stays on only when `asy_run` is 1.
- R6: `wake_src` bit order is 0 level external interrupt, 1 edge external interrupt, 2 pin change, 3 asynchronous timer, 4 ADC complete, 5 other internal interrupt. Idle accepts every source. Every other mode accepts bits 0 and 2. ADC noise reduction also accepts bit 4. ADC noise reduction and power-save also accept bit 3, but only when `asy_run` is 1. Sources that are not accepted leave the block asleep.
- R7: When the edge at clock k samples an accepted wake source, `irq_release` is high for exactly one cycle, in the cycle after edge k+S+4. S is `STARTUP_LONG` for power-down and power-save and 0 for every other mode. All clocks are enabled again during the last four of these cycles.
- R8: `sleeping` is high from the cycle after the entry edge up to and including the last halt cycle, and it is low in the cycle where `irq_release` is high.
- R9: A `rst_req` while `sleeping` is high takes priority over a wake that arrives in the same cycle. It ends sleep at the next edge, pulses `restart` for one cycle, never produces `irq_release` for that sleep, and clears the control register.
- R10: A `rst_req` while awake clears the control register and produces no `restart` pulse.
- R11: While awake, `wake_src` is ignored. While asleep, including the start-up and halt phases, a further `sleep_stb` is ignored and a wake arriving after the first one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low synchronous reset of the controller |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 4 | Bit 0 sleep-enable, bits 3:1 mode code |
| sleep_stb | input | 1 | One-cycle pulse from an executed sleep instruction |
| rst_req | input | 1 | System reset request (pin, watchdog, brown-out) |
| asy_run | input | 1 | Asynchronous timer is clocked from its own oscillator |
| wake_src | input | 6 | Pending enabled interrupt sources |
| clk_en | output | 5 | Per-domain clock enables |
| sleeping | output | 1 | Core is asleep or still waking |
| irq_release | output | 1 | One-cycle pulse letting the CPU take the interrupt |
| restart | output | 1 | One-cycle pulse: resume from the reset vector |

## Verification
Two functions can fall in the same cycle: a reset request and an accepted wake source, both arriving while the block sleeps. The bench provokes this by raising `rst_req` and a wake bit in the same cycle. It then requires a single `restart` pulse, and no `irq_release` over the following twenty cycles. The bench also ends a wait that is already in progress with a reset during the start-up phase. It pairs a register write with a strobe in the same cycle, and checks that the strobe uses the value stored before that write.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;
  localparam int N_DOM  = 5;
  localparam int N_WAKE = 6;

  localparam int D_CPU = 0, D_FLASH = 1, D_IO = 2, D_ADC = 3, D_ASY = 4;
  localparam int W_LVL = 0, W_EDGE = 1, W_PIN = 2, W_ASY = 3, W_ADC = 4, W_INT = 5;

  typedef enum logic [2:0] {
    M_IDLE  = 3'b000,
    M_ADCNR = 3'b001,
    M_PDOWN = 3'b010,
    M_PSAVE = 3'b011,
    M_STBY  = 3'b110
  } smode_e;

  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_START, S_HALT} pstate_e;

  // Unused codes fall back to the lightest mode.
  function automatic smode_e norm_mode(input logic [2:0] code);
    case (code)
      3'b001:  return M_ADCNR;
      3'b010:  return M_PDOWN;
      3'b011:  return M_PSAVE;
      3'b110:  return M_STBY;
      default: return M_IDLE;
    endcase
  endfunction

  // Domains that keep their clock while asleep in mode m.
  function automatic logic [N_DOM-1:0] run_mask(input smode_e m, input logic asy);
    logic [N_DOM-1:0] k;
    k = '0;
    case (m)
      M_IDLE: begin
        k = '1;
        k[D_CPU]   = 1'b0;
        k[D_FLASH] = 1'b0;
      end
      M_ADCNR: begin
        k[D_ADC] = 1'b1;
        k[D_ASY] = asy;
      end
      M_PSAVE: k[D_ASY] = asy;
      default: k = '0;
    endcase
    return k;
  endfunction

  // Interrupt sources able to end sleep in mode m.
  function automatic logic [N_WAKE-1:0] wake_mask(input smode_e m, input logic asy);
    logic [N_WAKE-1:0] w;
    w = '0;
    w[W_LVL] = 1'b1;
    w[W_PIN] = 1'b1;
    case (m)
      M_IDLE:  w = '1;
      M_ADCNR: begin
        w[W_ADC] = 1'b1;
        w[W_ASY] = asy;
      end
      M_PSAVE: w[W_ASY] = asy;
      default: ;
    endcase
    return w;
  endfunction

  // Oscillator is stopped in these modes, so a start-up wait is needed.
  function automatic logic needs_startup(input smode_e m);
    return (m == M_PDOWN) || (m == M_PSAVE);
  endfunction
endpackage

// File: rtl/pwr_ctl_reg.sv
`timescale 1ns/1ps
module pwr_ctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_req,
  input  logic       we,
  input  logic [3:0] wdata,
  output logic       se,
  output logic [2:0] mode_code
);
  always_ff @(posedge clk) begin
    if (!rst_n || rst_req) begin
      se        <= 1'b0;
      mode_code <= 3'b000;
    end else if (we) begin
      se        <= wdata[0];
      mode_code <= wdata[3:1];
    end
  end

  a_r10_reset_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (!se && mode_code == 3'b000));
endmodule

// File: rtl/pwr_mode_decode.sv
`timescale 1ns/1ps
module pwr_mode_decode
  import pwr_pkg::*;
(
  input  logic [2:0]        mode_code,
  input  logic              asy_run,
  output logic [N_DOM-1:0]  keep_mask,
  output logic [N_WAKE-1:0] accept_mask,
  output logic              long_wait,
  output logic              idle_class
);
  smode_e m;
  always_comb begin
    m           = norm_mode(mode_code);
    keep_mask   = run_mask(m, asy_run);
    accept_mask = wake_mask(m, asy_run);
    long_wait   = needs_startup(m);
    idle_class  = (m == M_IDLE);
  end
endmodule

// File: rtl/pwr_wake_seq.sv
`timescale 1ns/1ps
module pwr_wake_seq
  import pwr_pkg::*;
#(
  parameter int STARTUP_LONG = 12,
  parameter int HALT_CYC     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              se,
  input  logic [2:0]        mode_code,
  input  logic              asy_run,
  input  logic              sleep_stb,
  input  logic              rst_req,
  input  logic [N_WAKE-1:0] wake_src,
  output logic [N_DOM-1:0]  clk_en,
  output logic              sleeping,
  output logic              irq_release,
  output logic              restart
);
  localparam int CMAX = (STARTUP_LONG > HALT_CYC) ? STARTUP_LONG : HALT_CYC;
  localparam int CW   = $clog2(CMAX + 1);

  pstate_e           st;
  logic [CW-1:0]     cnt;
  logic [2:0]        mode_q;
  logic [N_DOM-1:0]  keep_mask;
  logic [N_WAKE-1:0] accept_mask;
  logic              long_wait;
  logic              idle_class;

  // Named internal events, also used by the assertions.
  logic entry_go, wake_hit, halt_last, clocks_off, use_long;

  pwr_mode_decode u_dec (
    .mode_code  (mode_q),
    .asy_run    (asy_run),
    .keep_mask  (keep_mask),
    .accept_mask(accept_mask),
    .long_wait  (long_wait),
    .idle_class (idle_class)
  );

  always_comb begin
    entry_go   = (st == S_RUN) && sleep_stb && se;
    wake_hit   = (st == S_SLEEP) && |(wake_src & accept_mask);
    halt_last  = (st == S_HALT) && (cnt == '0);
    clocks_off = (st == S_SLEEP) || (st == S_START);
    use_long   = long_wait && (STARTUP_LONG > 0);
    clk_en     = clocks_off ? keep_mask : '1;
    sleeping   = (st != S_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_RUN;
      cnt         <= '0;
      mode_q      <= 3'b000;
      irq_release <= 1'b0;
      restart     <= 1'b0;
    end else begin
      irq_release <= 1'b0;
      restart     <= 1'b0;
      if (rst_req) begin
        restart <= (st != S_RUN);
        st      <= S_RUN;
        cnt     <= '0;
      end else begin
        case (st)
          S_RUN: if (entry_go) begin
            st     <= S_SLEEP;
            mode_q <= mode_code;
          end
          S_SLEEP: if (wake_hit) begin
            if (use_long) begin
              st  <= S_START;
              cnt <= CW'(STARTUP_LONG - 1);
            end else begin
              st  <= S_HALT;
              cnt <= CW'(HALT_CYC - 1);
            end
          end
          S_START: if (cnt == '0) begin
            st  <= S_HALT;
            cnt <= CW'(HALT_CYC - 1);
          end else cnt <= cnt - 1'b1;
          S_HALT: if (cnt == '0) begin
            st          <= S_RUN;
            irq_release <= 1'b1;
          end else cnt <= cnt - 1'b1;
          default: st <= S_RUN;
        endcase
      end
    end
  end

  a_r2_no_entry_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && sleep_stb && !se && !rst_req) |=> (st == S_RUN));
  a_r3_cpu_gated_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP) |-> !clk_en[D_CPU]);
  a_r6_edge_irq_no_deep_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP && !idle_class && wake_src == 6'b000010 && !rst_req) |=> (st == S_SLEEP));
  a_r7_release_after_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_last && !rst_req) |=> (irq_release && !sleeping));
  a_r7_release_only_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
    irq_release |-> $past(st == S_HALT));
  a_r9_reset_wins_over_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && rst_req) |=> (restart && !irq_release && !sleeping));
  a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_release && restart));
endmodule

// File: rtl/pwr_sleep_ctrl.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl
  import pwr_pkg::*;
#(
  parameter int STARTUP_LONG = 12,
  parameter int HALT_CYC     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_wdata,
  input  logic              sleep_stb,
  input  logic              rst_req,
  input  logic              asy_run,
  input  logic [N_WAKE-1:0] wake_src,
  output logic [N_DOM-1:0]  clk_en,
  output logic              sleeping,
  output logic              irq_release,
  output logic              restart
);
  logic       se;
  logic [2:0] mode_code;

  pwr_ctl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_req  (rst_req),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .se       (se),
    .mode_code(mode_code)
  );

  pwr_wake_seq #(
    .STARTUP_LONG(STARTUP_LONG),
    .HALT_CYC    (HALT_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .se         (se),
    .mode_code  (mode_code),
    .asy_run    (asy_run),
    .sleep_stb  (sleep_stb),
    .rst_req    (rst_req),
    .wake_src   (wake_src),
    .clk_en     (clk_en),
    .sleeping   (sleeping),
    .irq_release(irq_release),
    .restart    (restart)
  );
endmodule

// File: tb/pwr_sleep_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_tb;
  localparam int LONG = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic       sleep_stb = 1'b0;
  logic       rst_req = 1'b0;
  logic       asy_run = 1'b0;
  logic [5:0] wake_src = '0;
  logic [4:0] clk_en;
  logic       sleeping, irq_release, restart;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  pwr_sleep_ctrl #(.STARTUP_LONG(LONG), .HALT_CYC(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sleep_stb(sleep_stb), .rst_req(rst_req), .asy_run(asy_run), .wake_src(wake_src),
    .clk_en(clk_en), .sleeping(sleeping), .irq_release(irq_release), .restart(restart)
  );

  // ---- expectations written from the requirements ----
  function automatic bit [4:0] exp_keep(bit [2:0] c, bit asy);
    if (c == 3'b001) return {asy, 1'b1, 3'b000};
    if (c == 3'b011) return {asy, 4'b0000};
    if (c == 3'b010 || c == 3'b110) return 5'b00000;
    return 5'b11100;
  endfunction

  function automatic bit accepts(bit [2:0] c, bit asy, int src);
    bit [5:0] ok;
    if (c == 3'b001)      ok = 6'b010101 | (asy ? 6'b001000 : 6'b0);
    else if (c == 3'b011) ok = 6'b000101 | (asy ? 6'b001000 : 6'b0);
    else if (c == 3'b010 || c == 3'b110) ok = 6'b000101;
    else ok = 6'b111111;
    return ok[src];
  endfunction

  function automatic int wait_of(bit [2:0] c);
    return (c == 3'b010 || c == 3'b011) ? LONG : 0;
  endfunction

  // ---- cycle model: remaining edges until release ----
  bit       m_asleep, m_rel, m_rst, r_se;
  bit [2:0] m_mode, r_mode;
  int       m_left;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_asleep <= 0; m_rel <= 0; m_rst <= 0; r_se <= 0; r_mode <= 0; m_mode <= 0; m_left <= -1;
    end else begin
      m_rel <= 0;
      m_rst <= 0;
      if (rst_req) begin
        r_se <= 0; r_mode <= 0;
        if (m_asleep) m_rst <= 1;
        m_asleep <= 0; m_left <= -1;
      end else begin
        if (cfg_we) begin r_se <= cfg_wdata[0]; r_mode <= cfg_wdata[3:1]; end
        if (!m_asleep) begin
          if (sleep_stb && r_se) begin m_asleep <= 1; m_mode <= r_mode; m_left <= -1; end
        end else if (m_left < 0) begin
          for (int s = 0; s < 6; s++)
            if (wake_src[s] && accepts(m_mode, asy_run, s)) m_left <= wait_of(m_mode) + 4;
        end else if (m_left == 1) begin
          m_asleep <= 0; m_rel <= 1; m_left <= -1;
        end else m_left <= m_left - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [4:0] e_en;
      e_en = (m_asleep && (m_left < 0 || m_left > 4)) ? exp_keep(m_mode, asy_run) : 5'b11111;
      vectors++;
      if (clk_en !== e_en || sleeping !== m_asleep || irq_release !== m_rel || restart !== m_rst) begin
        fails++;
        $display("FAIL %s cycle %0d: en/slp/rel/rst act %b/%b/%b/%b exp %b/%b/%b/%b", cur_req, cycles,
                 clk_en, sleeping, irq_release, restart, e_en, m_asleep, m_rel, m_rst);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      report();
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic write_cfg(input bit [2:0] c, input bit en);
    cfg_we = 1; cfg_wdata = {c, en}; step(); cfg_we = 0;
  endtask

  task automatic enter(input bit [2:0] c);
    write_cfg(c, 1'b1);
    sleep_stb = 1; step(); sleep_stb = 0;
  endtask

  // wake with one source, return edges from sampling edge to release edge
  task automatic wake_and_time(input int src, output int e);
    wake_src = 6'b1 << src; step(); wake_src = 0;
    e = 0;
    while (!irq_release && e < 200) begin step(); e++; end
  endtask

  initial begin
    int e;
    step(3);
    rst_n = 1;
    step();
    cur_req = "R1";
    chk(clk_en == 5'b11111, "R1 reset enables", clk_en, 31);
    chk(!sleeping && !irq_release && !restart, "R1 reset flags", sleeping, 0);
    sleep_stb = 1; step(); sleep_stb = 0; step();
    chk(!sleeping, "R1 enable cleared by reset", sleeping, 0);

    // R2: write in the strobe cycle does not count
    cur_req = "R2";
    write_cfg(3'b000, 1'b0);
    cfg_we = 1; cfg_wdata = 4'b0001; sleep_stb = 1; step(); cfg_we = 0; sleep_stb = 0; step();
    chk(!sleeping, "R2 same-cycle write", sleeping, 0);
    sleep_stb = 1; step(); sleep_stb = 0;
    chk(sleeping, "R2 entry with enable", sleeping, 1);
    wake_and_time(0, e);
    step(2);

    // R11: wake while awake is ignored
    cur_req = "R11";
    wake_src = 6'b111111; step(3); wake_src = 0;
    chk(!sleeping && !irq_release, "R11 wake while awake", sleeping, 0);

    // every mode code, both async-timer settings, every source
    for (int c = 0; c < 8; c++) begin
      for (int a = 0; a < 2; a++) begin
        for (int s = 0; s < 6; s++) begin
          asy_run = a[0];
          cur_req = (c == 1) ? "R4" : (c == 2 || c == 3 || c == 6) ? "R5" : "R3";
          enter(c[2:0]);
          chk(clk_en == exp_keep(c[2:0], a[0]), cur_req, clk_en, exp_keep(c[2:0], a[0]));
          cur_req = "R6";
          if (accepts(c[2:0], a[0], s)) begin
            cur_req = "R7";
            wake_and_time(s, e);
            chk(e == wait_of(c[2:0]) + 4, "R7 wake latency", e, wait_of(c[2:0]) + 4);
            chk(!sleeping, "R8 awake at release", sleeping, 0);
          end else begin
            wake_src = 6'b1 << s; step(); wake_src = 0; step(3);
            chk(sleeping, "R6 refused source", sleeping, 1);
            cur_req = "R11";
            sleep_stb = 1; step(); sleep_stb = 0;
            cur_req = "R7";
            wake_and_time(0, e);
            chk(e == wait_of(c[2:0]) + 4, "R7 level wake latency", e, wait_of(c[2:0]) + 4);
          end
          step(2);
        end
      end
    end
    asy_run = 0;

    // R11: second wake during start-up is ignored
    cur_req = "R11";
    enter(3'b010);
    wake_src = 6'b000001; step(); wake_src = 0; step(3);
    wake_src = 6'b000101; step(); wake_src = 0;
    e = 4;
    while (!irq_release && e < 200) begin step(); e++; end
    chk(e == LONG + 4, "R11 second wake ignored", e, LONG + 4);
    step(2);

    // R9: reset while asleep
    cur_req = "R9";
    enter(3'b010);
    step(2);
    rst_req = 1; step(); rst_req = 0;
    chk(restart && !sleeping && clk_en == 5'b11111, "R9 reset in sleep", restart, 1);
    step();
    sleep_stb = 1; step(); sleep_stb = 0;
    chk(!sleeping, "R9 register cleared", sleeping, 0);

    // R9: reset during start-up wait
    enter(3'b011);
    wake_src = 6'b000001; step(); wake_src = 0; step(3);
    rst_req = 1; step(); rst_req = 0;
    chk(restart && !sleeping, "R9 reset in start-up", restart, 1);
    for (int i = 0; i < 20; i++) begin
      step();
      chk(!irq_release, "R9 no release after reset", irq_release, 0);
    end

    // R9: reset and wake in the same cycle
    enter(3'b000);
    step();
    wake_src = 6'b000001; rst_req = 1; step(); wake_src = 0; rst_req = 0;
    chk(restart && !irq_release, "R9 reset beats wake", restart, 1);
    for (int i = 0; i < 20; i++) begin
      step();
      chk(!irq_release && !sleeping, "R9 coincident no release", irq_release, 0);
    end

    // R10: reset while awake
    cur_req = "R10";
    write_cfg(3'b010, 1'b1);
    rst_req = 1; step(); rst_req = 0;
    chk(!restart, "R10 no restart pulse", restart, 0);
    sleep_stb = 1; step(); sleep_stb = 0;
    chk(!sleeping, "R10 register cleared", sleeping, 0);
    step(3);
    report();
  end
endmodule